// File: doc/BRIEF.md
# Ready-latency TLP transmit streamer

This block feeds complete transaction-layer packets into a PCIe transmit stream whose ready input only takes effect two cycles after it is sampled. An internal producer presents packets as a plain word stream: the first word of each packet carries the header, followed by the payload words. The block buffers these words, frames them with start-of-packet and end-of-packet marks, and sends one beat per cycle for as long as the delayed ready allows.

The block never trusts the producer for framing. It reads the format and length fields of the header's first dword and works out how many beats the packet occupies. A mismatch between header and beat count would otherwise hang the receiving core. Both the ready input and every output are registered. A short start-up hold after reset keeps packets off the bus while the core settles. A two-entry skid buffer holds words that were already fetched while the core throttles, so every beat leaves exactly once and in order.

Top module: `tlp_tx_streamer`

## Requirements
- R1: While rst_ni is low, tx_valid_o, tx_sop_o and tx_eop_o are 0 and req_ready_o is 1.
- R2: No beat is sent during the first START_DLY (default 2) cycles after reset is released, even when tx_ready_i and req_valid_i are already high.
- R3: A beat is presented (tx_valid_o high) in cycle t only if tx_ready_i was high in cycle t-2, and only when a buffered word is available; every presented beat counts as accepted.
- R4: Once tx_ready_i goes low, tx_valid_o is low no later than two cycles afterwards.
- R5: When tx_ready_i is high in cycle t-2 and a word was buffered in cycle t-1, tx_valid_o is high in cycle t, including in the middle of a packet.
- R6: The beat count of a packet is ceil((H + P) / (BUS_W/32)). H is 4 when bit 29 of the header's first dword (bits [31:0] of the first word) is 1, else 3. P is 0 when bit 30 is 0. Otherwise P is bits [9:0], where the value 0 means 1024. Message packets use the 4-dword header case.
- R7: tx_sop_o is high only on the first beat of a packet and tx_eop_o only on its last beat. A one-beat packet raises both together. Neither is high without tx_valid_o.
- R8: Words leave on tx_data_o in the order they were accepted on the request side, none dropped and none repeated.
- R9: A request word is taken in a cycle with req_valid_i and req_ready_o both high. req_ready_o is low exactly when SKID_DEPTH (default 2) words are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request word present |
| req_word_i | input | BUS_W | Request word: header first, then payload |
| req_ready_o | output | 1 | Skid buffer can take a word |
| tx_ready_i | input | 1 | Core ready, effective two cycles later |
| tx_valid_o | output | 1 | Beat valid toward the core |
| tx_data_o | output | BUS_W | Beat data |
| tx_sop_o | output | 1 | First beat of a packet |
| tx_eop_o | output | 1 | Last beat of a packet |

## Verification
The bench targets the edges of the two-cycle latency. Lone ready drops and long stalls show whether valid falls and rises in the right cycle. A design off by one cycle would either send a beat the core refuses or leave a gap mid-packet. Headers with zero length (1024 dwords), 3- and 4-dword layouts with and without data, and one-beat packets test the beat count. A wrong count shows up as a misplaced end-of-packet mark. Full-buffer stalls check that the skid buffer neither overwrites nor replays a word. Start-up with ready already high tests the post-reset hold.

// File: rtl/tlp_tx_pkg.sv
package tlp_tx_pkg;
  localparam int unsigned LEN_MAX = 1024;
  localparam int unsigned CNT_W   = 11;
  typedef logic [CNT_W-1:0] beat_cnt_t;

  // dw0[29]: 4-dword header, dw0[30]: payload present, dw0[9:0]: length (0 = 1024)
  function automatic beat_cnt_t tlp_beats(input logic [31:0] dw0, input int unsigned dw_per_beat);
    int unsigned hdr_dw;
    int unsigned pay_dw;
    hdr_dw = dw0[29] ? 4 : 3;
    if (!dw0[30])              pay_dw = 0;
    else if (dw0[9:0] == '0)   pay_dw = LEN_MAX;
    else                       pay_dw = 32'(dw0[9:0]);
    return beat_cnt_t'((hdr_dw + pay_dw + dw_per_beat - 1) / dw_per_beat);
  endfunction
endpackage

// File: rtl/tlp_tx_skid.sv
module tlp_tx_skid #(
  parameter int unsigned W     = 128,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         ready_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign ready_o = (cnt_q < CW'(DEPTH));
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_inc(wr_q);
      if (pop_i)  rd_q <= ptr_inc(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && wr_q == PW'(i)) mem_q[i] <= data_i;
    end
  end

  AST_SKID_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> ready_o); // R9
  AST_SKID_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R8
endmodule

// File: rtl/tlp_tx_framer.sv
module tlp_tx_framer
  import tlp_tx_pkg::*;
#(
  parameter int unsigned DW_PER_BEAT = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        launch_i,
  input  logic [31:0] head_dw0_i,
  output logic        sop_o,
  output logic        eop_o,
  output logic        in_pkt_o
);
  logic      in_pkt_q;
  beat_cnt_t remain_q;
  beat_cnt_t beats_new;

  assign beats_new = tlp_beats(head_dw0_i, DW_PER_BEAT);
  assign sop_o     = !in_pkt_q;
  assign eop_o     = in_pkt_q ? (remain_q == beat_cnt_t'(1)) : (beats_new == beat_cnt_t'(1));
  assign in_pkt_o  = in_pkt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q <= 1'b0;
      remain_q <= '0;
    end else if (launch_i) begin
      if (!in_pkt_q) begin
        in_pkt_q <= (beats_new > beat_cnt_t'(1));
        remain_q <= beats_new - beat_cnt_t'(1);
      end else begin
        if (remain_q == beat_cnt_t'(1)) in_pkt_q <= 1'b0;
        remain_q <= remain_q - beat_cnt_t'(1);
      end
    end
  end

  AST_REMAIN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pkt_q |-> (remain_q != '0)); // R6
endmodule

// File: rtl/tlp_tx_streamer.sv
module tlp_tx_streamer
  import tlp_tx_pkg::*;
#(
  parameter int unsigned BUS_W      = 128,
  parameter int unsigned START_DLY  = 2,
  parameter int unsigned SKID_DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [BUS_W-1:0] req_word_i,
  output logic             req_ready_o,
  input  logic             tx_ready_i,
  output logic             tx_valid_o,
  output logic [BUS_W-1:0] tx_data_o,
  output logic             tx_sop_o,
  output logic             tx_eop_o
);
  localparam int unsigned DW_PER_BEAT = BUS_W / 32;
  localparam int unsigned SW          = $clog2(START_DLY + 1);

  logic             rdy_q;
  logic [SW-1:0]    start_q;
  logic             started;
  logic             skid_rdy, skid_empty, push, launch;
  logic [BUS_W-1:0] head;
  logic             f_sop, f_eop, in_pkt;

  assign started     = (start_q == SW'(START_DLY));
  assign push        = req_valid_i && skid_rdy;
  assign req_ready_o = skid_rdy;
  // launch in cycle t-1 puts a beat on the bus in cycle t; rdy_q holds ready of t-2
  assign launch      = started && rdy_q && !skid_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b0;
      start_q <= '0;
    end else begin
      rdy_q <= tx_ready_i;
      if (!started) start_q <= start_q + 1'b1;
    end
  end

  tlp_tx_skid #(.W(BUS_W), .DEPTH(SKID_DEPTH)) i_skid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (req_word_i),
    .pop_i   (launch),
    .data_o  (head),
    .empty_o (skid_empty),
    .ready_o (skid_rdy)
  );

  tlp_tx_framer #(.DW_PER_BEAT(DW_PER_BEAT)) i_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .head_dw0_i (head[31:0]),
    .sop_o      (f_sop),
    .eop_o      (f_eop),
    .in_pkt_o   (in_pkt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_sop_o   <= 1'b0;
      tx_eop_o   <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= launch;
      tx_sop_o   <= launch && f_sop;
      tx_eop_o   <= launch && f_eop;
      if (launch) tx_data_o <= head;
    end
  end

  // beat-count checker fed from the output ports only
  beat_cnt_t chk_seen_q, chk_exp_q, out_beats;
  assign out_beats = tlp_beats(tx_data_o[31:0], DW_PER_BEAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_seen_q <= '0;
      chk_exp_q  <= '0;
    end else if (tx_valid_o) begin
      if (tx_sop_o) begin
        chk_seen_q <= beat_cnt_t'(1);
        chk_exp_q  <= out_beats;
      end else begin
        chk_seen_q <= chk_seen_q + beat_cnt_t'(1);
      end
    end
  end

  AST_RL_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(tx_ready_i, 2)); // R3
  AST_DROP_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_q) |=> !tx_valid_o); // R4
  AST_START_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started |=> !tx_valid_o); // R2
  AST_MID_REASSERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_pkt && rdy_q && !skid_empty) |=> tx_valid_o); // R5
  AST_MARK_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_sop_o || tx_eop_o) |-> tx_valid_o); // R7
  AST_BEAT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_eop_o) |->
      (tx_sop_o ? (out_beats == beat_cnt_t'(1)) : (chk_seen_q + beat_cnt_t'(1) == chk_exp_q))); // R6
  AST_BEAT_NOT_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_sop_o && !tx_eop_o) |-> (chk_seen_q + beat_cnt_t'(1) < chk_exp_q)); // R6
endmodule

// File: tb/test_tlp_tx_streamer.sv
module test_tlp_tx_streamer;
  localparam int BW  = 128;
  localparam int DPB = BW / 32;
  localparam int WD  = 20000;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [BW-1:0] req_word_i = '0;
  logic          req_ready_o;
  logic          tx_ready_i = 1'b1;
  logic          tx_valid_o;
  logic [BW-1:0] tx_data_o;
  logic          tx_sop_o, tx_eop_o;

  always #2 clk = ~clk;

  tlp_tx_streamer #(.BUS_W(BW)) i_tlp_tx_streamer (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_word_i(req_word_i), .req_ready_o(req_ready_o),
    .tx_ready_i(tx_ready_i), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
    .tx_sop_o(tx_sop_o), .tx_eop_o(tx_eop_o)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [BW-1:0] gen_w[$];
  bit            gen_s[$];
  bit            gen_e[$];
  bit            rq[$];
  int            cnt_h[$];
  logic [15:0]   lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // beats = ceil((hdr + payload) / DPB), per R6
  function automatic int beats_of(input logic [2:0] fmt, input int len);
    int hd, pd;
    hd = fmt[0] ? 4 : 3;
    pd = !fmt[1] ? 0 : ((len % 1024) == 0 ? 1024 : len % 1024);
    return (hd + pd + DPB - 1) / DPB;
  endfunction

  task automatic add_pkt(input logic [2:0] fmt, input int len, input int id);
    int nb;
    logic [31:0] dw0;
    logic [BW-1:0] w;
    nb  = beats_of(fmt, len);
    dw0 = '0;
    dw0[31:29] = fmt;
    dw0[23:16] = id[7:0];
    dw0[9:0]   = len[9:0];
    for (int b = 0; b < nb; b++) begin
      w = '0;
      w[BW-1 -: 16] = id[15:0];
      w[BW-17 -: 16] = b[15:0];
      w[63:32] = ~{id[15:0], b[15:0]};
      w[31:0]  = (b == 0) ? dw0 : {16'hD0D0, b[15:0]};
      gen_w.push_back(w);
      gen_s.push_back(b == 0);
      gen_e.push_back(b == nb - 1);
    end
  endtask

  function automatic bit ready_at(input int t, input logic [15:0] r);
    if (t < 150) return 1'b1;
    if ((t % 97) < 12) return 1'b0;
    return (r[1:0] != 2'b00);
  endfunction

  initial begin
    int t, pi, vi, pushes, cnt_now, cnt_prev;
    bit push_now, exp_v;
    string tag;

    add_pkt(3'b000, 0, 1);      // 3DW no data: 1 beat
    add_pkt(3'b001, 7, 2);      // 4DW no data: 1 beat
    add_pkt(3'b010, 1, 3);      // 3DW + 1: 1 beat
    add_pkt(3'b010, 2, 4);      // 2 beats
    add_pkt(3'b011, 4, 5);      // 2 beats
    add_pkt(3'b011, 5, 6);      // message, 3 beats
    add_pkt(3'b010, 0, 7);      // 1024 dwords: 257 beats
    add_pkt(3'b011, 1023, 8);   // 257 beats
    for (int k = 0; k < 24; k++) add_pkt(3'(k % 4), 1 + (k * 5) % 29, 9 + k);
    add_pkt(3'b011, 0, 40);     // 1024 dwords, 4DW: 257 beats

    // reset with ready and request already high
    req_valid_i = 1'b1;
    req_word_i  = gen_w[0];
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tx_valid_o == 1'b0, "R1 valid in reset", BW'(tx_valid_o), '0);
    check(!tx_sop_o && !tx_eop_o, "R1 marks in reset", BW'({tx_sop_o, tx_eop_o}), '0);
    check(req_ready_o == 1'b1, "R1 req_ready in reset", BW'(req_ready_o), BW'(1));
    @(posedge clk);
    #1 rst_ni = 1'b1;

    t = 0; pi = 0; vi = 0; pushes = 0; cnt_prev = 0;
    while (vi < gen_w.size() && t < WD) begin
      tx_ready_i  = ready_at(t, lfsr);
      lfsr        = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_valid_i = (pi < gen_w.size());
      req_word_i  = (pi < gen_w.size()) ? gen_w[pi] : '0;
      rq.push_back(tx_ready_i);
      @(negedge clk);
      if (t < 2) check(tx_valid_o == 1'b0, "R2 start hold", BW'(tx_valid_o), '0);
      exp_v = (t >= 3) && rq[t-2] && (cnt_prev > 0);
      if (exp_v) tag = "R5 valid late/missing";
      else if (t < 3) tag = "R2 valid too early";
      else if (!rq[t-2]) tag = "R4 valid after ready drop";
      else tag = "R3 valid without word";
      check(tx_valid_o == exp_v, tag, BW'(tx_valid_o), BW'(exp_v));
      if (tx_valid_o) begin
        if (vi < gen_w.size()) begin
          check(tx_data_o == gen_w[vi], "R8 beat data", tx_data_o, gen_w[vi]);
          check(tx_sop_o == gen_s[vi], "R7 sop", BW'(tx_sop_o), BW'(gen_s[vi]));
          check(tx_eop_o == gen_e[vi], "R6/R7 eop", BW'(tx_eop_o), BW'(gen_e[vi]));
        end
        vi++;
      end else begin
        check(!tx_sop_o && !tx_eop_o, "R7 marks without valid", BW'({tx_sop_o, tx_eop_o}), '0);
      end
      cnt_now = pushes - vi;
      check(req_ready_o == (cnt_now < 2), "R9 req_ready", BW'(req_ready_o), BW'(cnt_now < 2));
      cnt_h.push_back(cnt_now);
      cnt_prev = cnt_now;
      push_now = req_valid_i && req_ready_o;
      @(posedge clk);
      #1;
      if (push_now) begin
        pi++;
        pushes++;
      end
      t++;
    end

    if (t >= WD) check(1'b0, "R3 watchdog expired", BW'(vi), BW'(gen_w.size()));
    req_valid_i = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check(tx_valid_o == 1'b0, "R8 no extra beat", BW'(tx_valid_o), '0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule